// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns each accepted READ or WRITE command of a four-bank SDRAM controller into the stream of column addresses for one burst. The row holds 256 columns. A small mode register holds three settings: the burst length (1, 2, 4, 8 or a whole 256-column page), the beat ordering (sequential or interleaved) and the read latency (2 or 3 clocks). The burst length and ordering are captured when the command is accepted. Changing the mode afterwards does not alter a burst that is already running.

The sequencer issues one column per clock, starting the cycle after the command. It marks the final beat of a fixed-length burst and raises an auto-precharge request for the burst's bank on that same beat when the command asked for one. A later READ or WRITE replaces the running burst at once. A burst-stop command ends it. Whole-page bursts wrap around the row and run until one of those two events. For reads, a strobe marks the cycle in which the data for each read beat is due on the data bus.

Top module: `burst_col_seq`

## Requirements
- R1: After reset no beat, last-beat, auto-precharge or read-data strobe is asserted, and the mode is length 1, sequential order, latency 2.
- R2: When cfgLoad is high at a clock edge, the mode is captured. cfgLenCode 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. Code 7 selects a whole page. Codes 4 to 6 act as length 1. cfgInterleave=1 selects interleaved order. cfgCasLat=3 selects latency 3 and any other value selects latency 2. A burst already running keeps the length and order it started with.
- R3: cmdOp is only acted on while cmdValid is high, with 2'b01 = READ, 2'b10 = WRITE, 2'b11 = burst stop and 2'b00 = no operation. For READ and WRITE, cmdAddr[7:0] is the start column and cmdAddr[10] requests auto-precharge. The first beat appears in the cycle after the command, with colAddr equal to the start column and colBank equal to cmdBank.
- R4: The beats of a fixed-length burst come on consecutive cycles, exactly as many as the burst length. lastBeat is high on the final beat only, and no beat follows unless a new command arrives.
- R5: In sequential order, beat i carries column (start + i) modulo the burst length inside the aligned block that contains the start column. The upper column bits are kept.
- R6: In interleaved order with a fixed length, beat i carries the start column XOR i.
- R7: A whole-page burst runs through columns start, start+1, and so on. It wraps from 255 to 0 and never asserts lastBeat. Interleaved order is ignored for it.
- R8: A READ or WRITE accepted during a burst makes the next cycle show the new burst's first beat. The replaced burst gives no lastBeat and no auto-precharge.
- R9: A burst stop leaves no beat in the following cycle, with no lastBeat and no auto-precharge. A stop while idle has no effect.
- R10: apValid is high, with apBank equal to the burst's bank, on the final beat of a fixed-length burst whose command set cmdAddr[10]. It is never high for whole-page bursts or without that request.
- R11: rdDataDue pulses once, exactly the latency (2 or 3) cycles after each read beat. It never pulses for write beats.
- R12: beatIsRead is high on the beats of a READ burst and low on the beats of a WRITE burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| cfgLoad | input | 1 | Capture the mode fields this cycle |
| cfgLenCode | input | 3 | Burst length code |
| cfgInterleave | input | 1 | 1 = interleaved beat order |
| cfgCasLat | input | 2 | Read latency, 2 or 3 |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 2 | Command opcode |
| cmdBank | input | BANK_W (2) | Bank of the command |
| cmdAddr | input | ADDR_W (11) | Start column in bits 7:0, auto-precharge request in bit 10 |
| beatValid | output | 1 | A column beat is issued this cycle |
| colAddr | output | 8 | Column of the current beat |
| colBank | output | BANK_W (2) | Bank of the current beat |
| lastBeat | output | 1 | Current beat ends a fixed-length burst |
| beatIsRead | output | 1 | Current beat belongs to a READ |
| rdDataDue | output | 1 | Read data for an earlier beat is due now |
| apValid | output | 1 | Auto-precharge request for apBank |
| apBank | output | BANK_W (2) | Bank to precharge |

## Verification
A wrong beat index or a wrong wrap mask shows up as a wrong colAddr on the very next beat. Interleaved and sequential orders separate only from the second beat onward, and only for start columns that are not block-aligned. A stale active flag or a bad down-counter shows at the ports as a missing or extra beat, or a misplaced lastBeat, in the first cycle after the expected burst end. A latency tap one stage off moves rdDataDue by exactly one cycle against the read beats. The stimulus therefore uses unaligned start columns, truncation by both command kinds, a page wrap past column 255, and reads under both latencies.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int COL_W = 8;
  localparam logic [2:0] LEN_PAGE = 3'd7;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_STOP  = 2'b11
  } cmdOp_t;

  // Strobes and per-burst settings passed from control to datapath
  typedef struct packed {
    logic             load;
    logic             step;
    logic             interleave;
    logic [COL_W-1:0] wrapMask;
  } seqStrobe_t;

  // Low-bit mask that wraps the column within the burst block
  function automatic logic [COL_W-1:0] lenMask(input logic [2:0] code);
    logic [COL_W-1:0] m;
    case (code)
      3'd1:     m = COL_W'(1);
      3'd2:     m = COL_W'(3);
      3'd3:     m = COL_W'(7);
      LEN_PAGE: m = '1;
      default:  m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgLoad,
  input  logic [2:0] cfgLenCode,
  input  logic       cfgInterleave,
  input  logic [1:0] cfgCasLat,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       apReq,
  output seqStrobe_t strobe,
  output logic       beatValid,
  output logic       lastBeat,
  output logic       apValid,
  output logic       beatIsRead,
  output logic       rdDataDue
);

  localparam int DUE_DEPTH = 3;

  logic [2:0]       modeLen;
  logic             modeIlv;
  logic             modeCl3;
  logic             active;
  logic             fullPage;
  logic             apFlag;
  logic             isRead;
  logic [COL_W-1:0] beatsLeft;
  logic [DUE_DEPTH-1:0] dueSr;

  logic isRw, isStop, lastNow;

  always_comb begin
    isRw    = cmdValid && (cmdOp == OP_READ || cmdOp == OP_WRITE);
    isStop  = cmdValid && (cmdOp == OP_STOP);
    lastNow = active && !fullPage && (beatsLeft == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeLen   <= 3'd0;
      modeIlv   <= 1'b0;
      modeCl3   <= 1'b0;
      active    <= 1'b0;
      fullPage  <= 1'b0;
      apFlag    <= 1'b0;
      isRead    <= 1'b0;
      beatsLeft <= '0;
      dueSr     <= '0;
    end else begin
      if (cfgLoad) begin
        modeLen <= cfgLenCode;
        modeIlv <= cfgInterleave;
        modeCl3 <= (cfgCasLat == 2'd3);
      end
      if (isRw) begin
        active    <= 1'b1;
        fullPage  <= (modeLen == LEN_PAGE);
        beatsLeft <= lenMask(modeLen);
        apFlag    <= apReq;
        isRead    <= (cmdOp == OP_READ);
      end else if (isStop || lastNow) begin
        active <= 1'b0;
      end else if (active) begin
        beatsLeft <= beatsLeft - 1'b1;
      end
      dueSr <= {dueSr[DUE_DEPTH-2:0], active && isRead};
    end
  end

  always_comb begin
    strobe.load       = isRw;
    strobe.step       = active && !isRw;
    strobe.interleave = modeIlv && (modeLen != LEN_PAGE);
    strobe.wrapMask   = lenMask(modeLen);
    beatValid         = active;
    lastBeat          = lastNow;
    apValid           = lastNow && apFlag;
    beatIsRead        = active && isRead;
    rdDataDue         = modeCl3 ? dueSr[2] : dueSr[1];
  end

endmodule

// File: rtl/bcs_dpath.sv
module bcs_dpath
  import bcs_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic [BANK_W-1:0] cmdBank,
  output logic [COL_W-1:0]  colAddr,
  output logic [BANK_W-1:0] colBank
);

  logic [COL_W-1:0]  startCol;
  logic [COL_W-1:0]  beatIdx;
  logic [COL_W-1:0]  mask;
  logic              ilv;
  logic [BANK_W-1:0] bankQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startCol <= '0;
      beatIdx  <= '0;
      mask     <= '0;
      ilv      <= 1'b0;
      bankQ    <= '0;
    end else if (strobe.load) begin
      startCol <= cmdCol;
      beatIdx  <= '0;
      mask     <= strobe.wrapMask;
      ilv      <= strobe.interleave;
      bankQ    <= cmdBank;
    end else if (strobe.step) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end

  logic [COL_W-1:0] seqCol, ilvCol;

  always_comb begin
    seqCol  = (startCol & ~mask) | ((startCol + beatIdx) & mask);
    ilvCol  = startCol ^ beatIdx;
    colAddr = ilv ? ilvCol : seqCol;
    colBank = bankQ;
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 11,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [2:0]        cfgLenCode,
  input  logic              cfgInterleave,
  input  logic [1:0]        cfgCasLat,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              beatValid,
  output logic [COL_W-1:0]  colAddr,
  output logic [BANK_W-1:0] colBank,
  output logic              lastBeat,
  output logic              beatIsRead,
  output logic              rdDataDue,
  output logic              apValid,
  output logic [BANK_W-1:0] apBank
);

  seqStrobe_t strobe;
  logic       unusedAddrBits;

  assign unusedAddrBits = ^cmdAddr[ADDR_W-1:COL_W];

  bcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgLoad(cfgLoad), .cfgLenCode(cfgLenCode),
    .cfgInterleave(cfgInterleave), .cfgCasLat(cfgCasLat),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .apReq(cmdAddr[AP_BIT]),
    .strobe(strobe), .beatValid(beatValid), .lastBeat(lastBeat),
    .apValid(apValid), .beatIsRead(beatIsRead), .rdDataDue(rdDataDue)
  );

  bcs_dpath #(.BANK_W(BANK_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdCol(cmdAddr[COL_W-1:0]), .cmdBank(cmdBank),
    .colAddr(colAddr), .colBank(colBank)
  );

  assign apBank = colBank;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [1:0]       cmdOp,
  input logic [COL_W-1:0] cmdCol,
  input logic             beatValid,
  input logic             lastBeat,
  input logic [COL_W-1:0] colAddr,
  input logic             apValid,
  input logic             beatIsRead,
  input logic             rdDataDue
);

  logic newCmd, stopCmd, quiet;
  assign newCmd  = cmdValid && (cmdOp == OP_READ || cmdOp == OP_WRITE);
  assign stopCmd = cmdValid && (cmdOp == OP_STOP);
  assign quiet   = !cmdValid || (cmdOp == OP_NOP);

  assert_last_in_beat_R4: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid);

  assert_ap_on_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    apValid |-> lastBeat);

  assert_first_col_R3: assert property (@(posedge clk) disable iff (!rstN)
    newCmd |=> (beatValid && colAddr == $past(cmdCol)));

  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> !beatValid);

  assert_end_after_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !newCmd) |=> !beatValid);

  assert_continue_R4: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !lastBeat && quiet) |=> beatValid);

  assert_due_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdDataDue |-> ($past(beatValid && beatIsRead, 2) || $past(beatValid && beatIsRead, 3)));

endmodule

bind burst_col_seq bcs_checker chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdCol(cmdAddr[7:0]), .beatValid(beatValid), .lastBeat(lastBeat),
  .colAddr(colAddr), .apValid(apValid), .beatIsRead(beatIsRead),
  .rdDataDue(rdDataDue)
);

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;

  localparam logic [1:0] RD = 2'b01, WR = 2'b10, STP = 2'b11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [2:0]  cfgLenCode = 3'd0;
  logic        cfgInterleave = 1'b0;
  logic [1:0]  cfgCasLat = 2'd2;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'b00;
  logic [1:0]  cmdBank = 2'd0;
  logic [10:0] cmdAddr = '0;
  logic        beatValid, lastBeat, beatIsRead, rdDataDue, apValid;
  logic [7:0]  colAddr;
  logic [1:0]  colBank, apBank;

  burst_col_seq dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgLenCode(cfgLenCode),
    .cfgInterleave(cfgInterleave), .cfgCasLat(cfgCasLat),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .beatValid(beatValid), .colAddr(colAddr), .colBank(colBank),
    .lastBeat(lastBeat), .beatIsRead(beatIsRead), .rdDataDue(rdDataDue),
    .apValid(apValid), .apBank(apBank)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0] col;
    logic [1:0] bank;
    logic       last;
    logic       ap;
    logic       rd;
  } beat_t;

  beat_t expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  // bench copy of the mode, updated after the capturing edge
  logic [2:0] bLen = 3'd0;
  logic       bIlv = 1'b0;
  int         bCl  = 2;
  logic [2:0] expRdHist = '0;

  function automatic int blOf(input logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] expCol(input logic [7:0] start, input int i);
    logic [7:0] m, k;
    k = 8'(i);
    if (bLen == 3'd7) return start + k;          // R7 whole page, plain wrap
    m = 8'(blOf(bLen) - 1);
    if (bIlv) return start ^ k;                  // R6
    return (start & ~m) | ((start + k) & m);     // R5
  endfunction

  task automatic setMode(input logic [2:0] len, input logic ilv, input int cl);
    cfgLoad = 1'b1; cfgLenCode = len; cfgInterleave = ilv; cfgCasLat = 2'(cl);
    @(posedge clk); #1;
    cfgLoad = 1'b0;
    bLen = len; bIlv = ilv; bCl = (cl == 3) ? 3 : 2;
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] bank,
                       input logic [7:0] col, input logic ap,
                       input int gap, input int allowed, input string tag);
    int n;
    beat_t it;
    if (bLen == 3'd7) n = allowed;
    else n = (blOf(bLen) < allowed) ? blOf(bLen) : allowed;
    for (int i = 0; i < n; i++) begin
      it.col  = expCol(col, i);
      it.bank = bank;
      it.last = (bLen != 3'd7) && (i == blOf(bLen) - 1);
      it.ap   = it.last && ap;
      it.rd   = (op == RD);                      // R12
      expQ.push_back(it);
      tagQ.push_back(tag);
    end
    cmdValid = 1'b1; cmdOp = op; cmdBank = bank; cmdAddr = {ap, 2'b00, col};
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); #1;
      cmdValid = 1'b0; cmdOp = 2'b00;
    end
  endtask

  task automatic stopCmd(input int gap);
    cmdValid = 1'b1; cmdOp = STP;
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); #1;
      cmdValid = 1'b0; cmdOp = 2'b00;
    end
  endtask

  task automatic idle(input int n);
    for (int g = 0; g < n; g++) begin
      @(posedge clk); #1;
    end
  endtask

  // monitor: pops expected beats and compares
  always @(negedge clk) begin
    if (rstN && !done) begin
      beat_t act, exp;
      logic  expRdNow, expDue;
      string tag;
      expRdNow = 1'b0;
      expDue = (bCl == 3) ? expRdHist[2] : expRdHist[1];
      if (beatValid) begin
        act = {colAddr, colBank, lastBeat, apValid, beatIsRead};
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R4/R9 unexpected beat: actual %h expected none", act);
        end else begin
          exp = expQ.pop_front();
          tag = tagQ.pop_front();
          expRdNow = exp.rd;
          if (act !== exp || (exp.ap && apBank !== exp.bank)) begin
            fails++;
            $display("FAIL %s beat: actual col=%h bank=%0d last=%b ap=%b rd=%b apBank=%0d expected col=%h bank=%0d last=%b ap=%b rd=%b",
                     tag, colAddr, colBank, lastBeat, apValid, beatIsRead, apBank,
                     exp.col, exp.bank, exp.last, exp.ap, exp.rd);
          end
        end
      end else if (lastBeat || apValid) begin
        checks++; fails++;
        $display("FAIL R4 flags without beat: actual last=%b ap=%b expected 0 0", lastBeat, apValid);
      end
      if (expDue || rdDataDue) begin
        checks++;
        if (rdDataDue !== expDue) begin
          fails++;
          $display("FAIL R11 rdDataDue: actual %b expected %b", rdDataDue, expDue);
        end
      end
      expRdHist = {expRdHist[1:0], expRdNow};
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    checks++;
    if ({beatValid, lastBeat, apValid, rdDataDue} !== 4'b0000) begin
      fails++;
      $display("FAIL R1 reset outputs: actual %b expected 0000",
               {beatValid, lastBeat, apValid, rdDataDue});
    end
    @(posedge clk); #1;
    rstN = 1'b1;

    // R1 default mode: one beat, latency 2; R10 auto-precharge on it
    issue(RD, 2'd1, 8'h35, 1'b1, 4, 4, "R1");

    // R5 sequential wrap in aligned block of 4, latency 3 (R2)
    setMode(3'd2, 1'b0, 3);
    issue(WR, 2'd2, 8'h1E, 1'b0, 6, 6, "R5");

    // R6 interleaved length 8 read with auto-precharge (R10, R11)
    setMode(3'd3, 1'b1, 2);
    issue(RD, 2'd0, 8'h5A, 1'b1, 10, 10, "R6");

    // R6 interleaved length 2 write from top column
    setMode(3'd1, 1'b1, 2);
    issue(WR, 2'd3, 8'hFF, 1'b1, 4, 4, "R6");

    // R8 new command replaces running burst
    setMode(3'd3, 1'b0, 3);
    issue(RD, 2'd3, 8'h10, 1'b1, 3, 3, "R8");
    issue(WR, 2'd1, 8'h44, 1'b1, 10, 10, "R8");

    // R9 burst stop, then a stop while idle
    issue(RD, 2'd2, 8'h80, 1'b1, 2, 2, "R9");
    stopCmd(4);
    stopCmd(4);

    // R7 whole page wraps past 255, interleave ignored, no last or ap
    setMode(3'd7, 1'b1, 2);
    issue(WR, 2'd0, 8'hFC, 1'b1, 260, 260, "R7");
    stopCmd(4);

    // R2 reserved length code acts as one beat
    setMode(3'd5, 1'b0, 2);
    issue(RD, 2'd1, 8'h33, 1'b0, 4, 4, "R2");

    // R2 mode change during a burst leaves it at length 4
    setMode(3'd2, 1'b0, 2);
    issue(WR, 2'd0, 8'h09, 1'b0, 1, 99, "R2");
    setMode(3'd0, 1'b0, 2);
    idle(6);
    // R2 new mode applies to the next command; R3 start column and bank
    issue(RD, 2'd2, 8'h77, 1'b1, 4, 4, "R3");

    // R11 latency 3 reads, R12 read flag
    setMode(3'd1, 1'b0, 3);
    issue(RD, 2'd2, 8'h40, 1'b0, 6, 6, "R11");
    idle(6);

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R4 missing beats: actual %0d left expected 0", expQ.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule